// File: doc/BRIEF.md
# Ternary-Weight Four-Lane Multiply-Accumulate Unit

This block is the datapath behind one coprocessor-style instruction for low-precision neural-network inference. A single 32-bit activation word carries four 8-bit activations. The low byte of a second word carries four 2-bit weights, each one of the values -2, -1, 0 or +1. The block multiplies each activation by its weight and sums the four products into one dot product.

That one dot product is then added to each of four signed 16-bit accumulator lanes, which arrive packed in a 64-bit word. Each lane saturates on its own. The four lanes go back as a 64-bit result one clock later, marked by a valid strobe.

A one-bit mode input chooses how the activation bytes are read. In signed mode (instruction code 0) each byte is a two's-complement value. In unsigned mode (instruction code 3) each byte is a plain magnitude. The surrounding core reads and writes the register file, decodes the instruction and checks access rights; this block does none of that.

Top module: `tmac_unit`

## Requirements
- R1: Weight field `wgt_word[2k+1:2k]` multiplies activation byte `act_word[8k+7:8k]` for k = 0..3. So bits [7:6] pair with [31:24] and bits [1:0] pair with [7:0].
- R2: A 2-bit weight is two's complement: 00 = 0, 01 = +1, 10 = -2, 11 = -1.
- R3: With `act_unsigned` = 0, each activation byte is sign-extended, so 0x80 is -128 and 0xFF is -1.
- R4: With `act_unsigned` = 1, each activation byte is read as a value from 0 to 255.
- R5: The same dot product is added to every lane. Lane k occupies bits [16k+15:16k] of both `acc_word` and `res_word`, and each lane is a signed 16-bit value that never carries into its neighbour.
- R6: A lane sum above +32767 returns 0x7FFF in that lane.
- R7: A lane sum below -32768 returns 0x8000 in that lane.
- R8: `wgt_word[31:8]` has no effect on the result.
- R9: A request presented with `valid_in` high at a rising edge gives its result on `res_word`, with `valid_out` high, after exactly that edge. Back-to-back requests give back-to-back results.
- R10: After an edge where `valid_in` is low, `valid_out` is low and `res_word` keeps its previous value.
- R11: While `rst_n` is low, `valid_out` is 0 and `res_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | Request strobe |
| act_unsigned | input | 1 | 1 selects unsigned activations, 0 selects signed |
| act_word | input | 32 | Four 8-bit activations |
| wgt_word | input | 32 | Four 2-bit weights in bits [7:0]; upper bits unused |
| acc_word | input | 64 | Four signed 16-bit accumulator lanes |
| valid_out | output | 1 | Result strobe, one cycle after `valid_in` |
| res_word | output | 64 | Four saturated 16-bit result lanes |

## Verification
The assertions check, on every cycle:
- the one-cycle relation between `valid_in` and `valid_out`;
- that the result holds through idle cycles;
- that an all-zero weight byte returns the accumulator unchanged;
- that every lane moves in the direction of the sign of the internal dot product.

Some behaviour only the bench's scenarios can show: the exact weight encoding, the pairing of weight fields to activation bytes, the difference between signed and unsigned reading, the exact clamp values at both limits, and that the upper weight bits are ignored. The bench shows these by comparing full 64-bit results against a model written from the requirements.

// File: rtl/tmac_pkg.sv
package tmac_pkg;
    localparam int ACT_W   = 8;
    localparam int WGT_W   = 2;
    localparam int TAPS    = 4;
    localparam int LANE_W  = 16;
    localparam int NLANE   = 4;
    localparam int ACTV_W  = ACT_W * TAPS;
    localparam int ACC_W   = LANE_W * NLANE;
    localparam int PROD_W  = ACT_W + 1 + WGT_W;
    localparam int SUM_W   = PROD_W + $clog2(TAPS);

    typedef struct packed {
        logic             valid;
        logic [ACC_W-1:0] res;
    } tmac_state_t;
endpackage

// File: rtl/tmac_tap.sv
module tmac_tap #(
    parameter int ACT_W  = 8,
    parameter int WGT_W  = 2,
    parameter int PROD_W = ACT_W + 1 + WGT_W
) (
    input  logic [ACT_W-1:0]         act_byte,
    input  logic [WGT_W-1:0]         wgt_code,
    input  logic                     act_unsigned,
    output logic signed [PROD_W-1:0] prod
);
    logic signed [ACT_W:0]   act_ext;
    logic signed [WGT_W-1:0] wgt_val;

    always_comb begin
        // The extra top bit carries the sign in signed mode and is zero in unsigned mode.
        act_ext = act_unsigned ? $signed({1'b0, act_byte})
                               : $signed({act_byte[ACT_W-1], act_byte});
        wgt_val = $signed(wgt_code);
        prod    = act_ext * wgt_val;
    end
endmodule

// File: rtl/tmac_dot.sv
module tmac_dot #(
    parameter int ACT_W  = 8,
    parameter int WGT_W  = 2,
    parameter int TAPS   = 4,
    parameter int PROD_W = ACT_W + 1 + WGT_W,
    parameter int SUM_W  = PROD_W + $clog2(TAPS)
) (
    input  logic [ACT_W*TAPS-1:0]   act_word,
    input  logic [WGT_W*TAPS-1:0]   wgt_field,
    input  logic                    act_unsigned,
    output logic signed [SUM_W-1:0] dot
);
    logic signed [PROD_W-1:0] prod [TAPS];

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        tmac_tap #(
            .ACT_W (ACT_W),
            .WGT_W (WGT_W),
            .PROD_W(PROD_W)
        ) u_tap (
            .act_byte    (act_word[k*ACT_W +: ACT_W]),
            .wgt_code    (wgt_field[k*WGT_W +: WGT_W]),
            .act_unsigned(act_unsigned),
            .prod        (prod[k])
        );
    end

    always_comb begin
        dot = '0;
        for (int k = 0; k < TAPS; k++) begin
            dot = dot + SUM_W'(prod[k]);
        end
    end
endmodule

// File: rtl/tmac_lane_sat.sv
module tmac_lane_sat #(
    parameter int LANE_W = 16,
    parameter int SUM_W  = 13,
    parameter int EXT_W  = ((SUM_W > LANE_W) ? SUM_W : LANE_W) + 1
) (
    input  logic [LANE_W-1:0]       lane_in,
    input  logic signed [SUM_W-1:0] dot,
    output logic [LANE_W-1:0]       lane_out
);
    localparam logic signed [EXT_W-1:0] HI_LIM = EXT_W'((2 ** (LANE_W - 1)) - 1);
    localparam logic signed [EXT_W-1:0] LO_LIM = -EXT_W'(2 ** (LANE_W - 1));

    logic signed [EXT_W-1:0] wide;

    always_comb begin
        wide = EXT_W'($signed(lane_in)) + EXT_W'(dot);
        if (wide > HI_LIM) begin
            lane_out = HI_LIM[LANE_W-1:0];
        end else if (wide < LO_LIM) begin
            lane_out = LO_LIM[LANE_W-1:0];
        end else begin
            lane_out = wide[LANE_W-1:0];
        end
    end
endmodule

// File: rtl/tmac_unit.sv
module tmac_unit
    import tmac_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_in,
    input  logic             act_unsigned,
    input  logic [31:0]      act_word,
    input  logic [31:0]      wgt_word,
    input  logic [63:0]      acc_word,
    output logic             valid_out,
    output logic [63:0]      res_word
);
    localparam int WFIELD_W = WGT_W * TAPS;

    logic signed [SUM_W-1:0] dot_sum;
    logic [ACC_W-1:0]        lanes_sat;
    tmac_state_t             st_d, st_q;

    tmac_dot #(
        .ACT_W (ACT_W),
        .WGT_W (WGT_W),
        .TAPS  (TAPS),
        .PROD_W(PROD_W),
        .SUM_W (SUM_W)
    ) u_dot (
        .act_word    (act_word[ACTV_W-1:0]),
        .wgt_field   (wgt_word[WFIELD_W-1:0]),
        .act_unsigned(act_unsigned),
        .dot         (dot_sum)
    );

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        tmac_lane_sat #(
            .LANE_W(LANE_W),
            .SUM_W (SUM_W)
        ) u_sat (
            .lane_in (acc_word[l*LANE_W +: LANE_W]),
            .dot     (dot_sum),
            .lane_out(lanes_sat[l*LANE_W +: LANE_W])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = valid_in;
        if (valid_in) begin
            st_d.res = lanes_sat;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_out = st_q.valid;
    assign res_word  = st_q.res;

    // R9
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_out);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> (!valid_out && $stable(res_word)));

    // R2
    zero_wgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && wgt_word[WFIELD_W-1:0] == '0) |=> res_word == $past(acc_word));

    for (genvar l = 0; l < NLANE; l++) begin : g_dir_chk
        // R5
        lane_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_in && dot_sum > 0) |=>
            $signed(res_word[l*LANE_W +: LANE_W]) >= $signed($past(acc_word[l*LANE_W +: LANE_W])));
        // R5
        lane_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_in && dot_sum < 0) |=>
            $signed(res_word[l*LANE_W +: LANE_W]) <= $signed($past(acc_word[l*LANE_W +: LANE_W])));
    end
endmodule

// File: tb/sim_tmac_unit.sv
module sim_tmac_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic        act_unsigned = 1'b0;
    logic [31:0] act_word = '0;
    logic [31:0] wgt_word = '0;
    logic [63:0] acc_word = '0;
    logic        valid_out;
    logic [63:0] res_word;

    int n_chk = 0;
    int n_bad = 0;
    logic [63:0] exp_q[$];
    string       tag_q[$];
    logic [63:0] last_res = '0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    tmac_unit u0 (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .act_unsigned(act_unsigned),
        .act_word(act_word), .wgt_word(wgt_word), .acc_word(acc_word),
        .valid_out(valid_out), .res_word(res_word)
    );

    function automatic logic [63:0] model(logic [31:0] a, logic [31:0] w, logic [63:0] acc, logic uns);
        int dot = 0;
        logic [63:0] r;
        for (int k = 0; k < 4; k++) begin
            int av;
            int wv;
            av = uns ? int'(a[8*k +: 8]) : int'($signed(a[8*k +: 8]));
            case (w[2*k +: 2])
                2'b00: wv = 0;
                2'b01: wv = 1;
                2'b10: wv = -2;
                default: wv = -1;
            endcase
            dot += av * wv;
        end
        for (int l = 0; l < 4; l++) begin
            int v;
            v = int'($signed(acc[16*l +: 16])) + dot;
            if (v > 32767) v = 32767;
            if (v < -32768) v = -32768;
            r[16*l +: 16] = 16'(v);
        end
        return r;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(string tag, logic [31:0] a, logic [31:0] w, logic [63:0] acc, logic uns);
        @(negedge clk);
        valid_in     = 1'b1;
        act_word     = a;
        wgt_word     = w;
        acc_word     = acc;
        act_unsigned = uns;
        exp_q.push_back(model(a, w, acc, uns));
        tag_q.push_back(tag);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            valid_in = 1'b0;
            act_word = $urandom;
            wgt_word = $urandom;
            acc_word = {$urandom, $urandom};
        end
    endtask

    // Monitor: every result strobe pops one expected item.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (valid_out) begin
                if (exp_q.size() == 0) begin
                    check("R9 unexpected strobe", 64'd1, 64'd0);
                end else begin
                    logic [63:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, res_word, e);
                    last_res = e;
                end
            end else begin
                // R10: idle cycle keeps the last result
                check("R10 hold", res_word, last_res);
            end
        end
    end

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 reset res", res_word, 64'd0);
        check("R11 reset valid", {63'd0, valid_out}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: each weight code on one activation of value 5
        drive("R2 w=+1", 32'h0000_0005, 32'h01, 64'h0010_0020_0030_0040, 1'b0);
        drive("R2 w=-1", 32'h0000_0005, 32'h03, 64'h0010_0020_0030_0040, 1'b0);
        drive("R2 w=-2", 32'h0000_0005, 32'h02, 64'h0010_0020_0030_0040, 1'b0);
        drive("R2 w=0",  32'h0000_0005, 32'h00, 64'h0010_0020_0030_0040, 1'b0);
        idle(2);
        // R1: field-to-byte pairing
        drive("R1 top pair", 32'h0403_0201, 32'h40, 64'h0, 1'b0);
        drive("R1 pair 2",   32'h0403_0201, 32'h10, 64'h0, 1'b0);
        drive("R1 mixed",    32'h0403_0201, 32'h9C, 64'h0, 1'b0);
        // R3 / R4: signed against unsigned reading
        drive("R3 signed",   32'h8080_80FF, 32'h55, 64'h0100_0200_0300_0400, 1'b0);
        drive("R4 unsigned", 32'h8080_80FF, 32'h55, 64'h0100_0200_0300_0400, 1'b1);
        drive("R3 signed neg w", 32'hF0F0_F0F0, 32'hAA, 64'h0, 1'b0);
        // R5: distinct lanes, no carry between lanes
        drive("R5 lanes", 32'h0102_0304, 32'h55, 64'hFFFF_7FF0_0000_8000, 1'b0);
        drive("R5 lanes unsigned", 32'h0102_0304, 32'h55, 64'h1234_FFF8_ABCD_0001, 1'b1);
        idle(1);
        // R6 / R7: clamps at both limits
        drive("R6 high clamp", 32'hFFFF_FFFF, 32'h55, 64'h7F00_7FFF_0000_7C05, 1'b1);
        drive("R7 low clamp",  32'hFFFF_FFFF, 32'hAA, 64'h8100_8000_0000_8800, 1'b1);
        drive("R6 signed high", 32'h8080_8080, 32'hAA, 64'h7FFF_7E00_7DFF_0000, 1'b0);
        // R8: upper weight bits ignored
        drive("R8 upper bits", 32'h0000_0005, 32'hFFFF_FF01, 64'h0010_0020_0030_0040, 1'b0);
        drive("R8 upper bits 2", 32'h1122_3344, 32'hA5A5_A500, 64'h1111_2222_3333_4444, 1'b1);
        idle(3);
        // R9: longer back-to-back burst
        for (int i = 0; i < 20; i++) begin
            drive("R9 burst", $urandom, $urandom, {$urandom, $urandom}, 1'($urandom));
        end
        idle(3);
        // R9: every request produced exactly one result
        check("R9 drained", 64'(exp_q.size()), 64'd0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule